// File: doc/BRIEF.md
# Split Timeout Register Pair

This block holds the two serial-bus split-timeout control registers, a whole-seconds part (hi) and a fraction-of-a-second part counted in bus cycles (lo), behind a plain 32-bit write/read port. Software or the bus agent picks one of the two registers with a select bit, writes a word, and reads either register back in its architectural bit alignment. The hi register occupies the low bits of its word. The lo register occupies the top 13 bits of its word.

A lo write is realigned, which means the top 13 bits are taken as the value, and the value is then clamped into the legal range before it is stored. A hi write keeps only its low three bits. The block also keeps a live total timeout in bus cycles, computed as hi × 8000 + lo. This total is always driven on an output for the local transaction logic. The total is registered and changes on the same clock edge as the register that was written.

A synchronous re-initialise input restores the power-on contents, as after a resume. Those contents are hi = 0 and lo = the clamped initial-value parameter.

Top module: `split_timeout_regs`

## Requirements
- R1: A lo write (wr_sel = 1) stores wr_data[31:19] as the lo value and ignores wr_data[18:0]. Reading lo (rd_sel = 1) returns the stored value in bits [31:19], with bits [18:0] zero.
- R2: A lo value below 800 is stored as 800, and a lo value above 7999 is stored as 7999. The values 800 and 7999 themselves are stored unchanged.
- R3: A hi write (wr_sel = 0) stores only wr_data[2:0]. Reading hi (rd_sel = 0) returns the value in bits [2:0], with bits [31:3] zero.
- R4: timeout_cycles always equals hi × 8000 + lo as a 16-bit value. It takes its new value at the same clock edge that stores a write.
- R5: After reset, hi reads 0, lo reads the clamped INIT_LO (800 by default), and timeout_cycles is 800.
- R6: A cycle with init_req high restores the reset contents of hi, lo and timeout_cycles, and it overrides any write presented in the same cycle.
- R7: With wr_en low, nothing changes whatever wr_data holds. A write to one register leaves the other register unchanged.
- R8: rd_data follows rd_sel combinationally, and reading never changes the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Synchronous re-initialise (resume) |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 1 | Write target: 0 = hi, 1 = lo |
| wr_data | input | 32 | Write word in architectural alignment |
| rd_sel | input | 1 | Read target: 0 = hi, 1 = lo |
| rd_data | output | 32 | Selected register, aligned |
| timeout_cycles | output | 16 | hi × 8000 + lo in bus cycles |

## Verification
The lo clamp is exercised with these raw values:
- 0, 799 and 8000, which must be pulled to a bound.
- 800 and 7999, which must pass unchanged.
- An all-ones word.

Together these separate an off-by-one bound from a correct one. Words with junk in the ignored low bits of lo, and in the upper bits of hi, tell a correct realignment and mask apart from a shifted or unmasked store. The combined value is read at the extremes (7, 7999) and at a mid-range pair, which exposes a wrong multiplier or a truncated width. A write that coincides with init_req, and writes with wr_en low, separate priority and hold errors from ordinary stores.

// File: rtl/st_pkg.sv
package st_pkg;
  typedef enum logic {
    SEL_HI = 1'b0,
    SEL_LO = 1'b1
  } st_sel_e;
endpackage

// File: rtl/st_lo_clamp.sv
module st_lo_clamp #(
  parameter int LO_W   = 13,
  parameter int LO_MIN = 800,
  parameter int LO_MAX = 7999
) (
  input  logic [LO_W-1:0] raw_val,
  output logic [LO_W-1:0] clamped
);
  localparam logic [LO_W-1:0] MIN_V = LO_W'(LO_MIN);
  localparam logic [LO_W-1:0] MAX_V = LO_W'(LO_MAX);

  always_comb begin
    if (raw_val < MIN_V)      clamped = MIN_V;
    else if (raw_val > MAX_V) clamped = MAX_V;
    else                      clamped = raw_val;
  end
endmodule

// File: rtl/st_combine.sv
module st_combine #(
  parameter int HI_W  = 3,
  parameter int LO_W  = 13,
  parameter int TMO_W = 16,
  parameter int CYC   = 8000
) (
  input  logic [HI_W-1:0]  hi,
  input  logic [LO_W-1:0]  lo,
  output logic [TMO_W-1:0] total
);
  localparam logic [TMO_W-1:0] CYC_V = TMO_W'(CYC);
  assign total = TMO_W'(hi) * CYC_V + TMO_W'(lo);
endmodule

// File: rtl/st_read_mux.sv
module st_read_mux #(
  parameter int WORD_W = 32,
  parameter int HI_W   = 3,
  parameter int LO_W   = 13
) (
  input  logic              sel,
  input  logic [HI_W-1:0]   hi,
  input  logic [LO_W-1:0]   lo,
  output logic [WORD_W-1:0] word
);
  import st_pkg::*;
  localparam int SHIFT = WORD_W - LO_W;

  always_comb begin
    if (st_sel_e'(sel) == SEL_LO) word = {lo, {SHIFT{1'b0}}};
    else                          word = {{(WORD_W-HI_W){1'b0}}, hi};
  end
endmodule

// File: rtl/split_timeout_regs.sv
module split_timeout_regs #(
  parameter int WORD_W  = 32,
  parameter int LO_W    = 13,
  parameter int HI_W    = 3,
  parameter int LO_MIN  = 800,
  parameter int LO_MAX  = 7999,
  parameter int CYC     = 8000,
  parameter int INIT_LO = 800,
  parameter int TMO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [WORD_W-1:0] rd_data,
  output logic [TMO_W-1:0]  timeout_cycles
);
  import st_pkg::*;

  logic [HI_W-1:0]  hi_q, hi_n;
  logic [LO_W-1:0]  lo_q, lo_n, lo_wr, lo_init;
  logic [TMO_W-1:0] tmo_q, tmo_n, tmo_init;

  st_lo_clamp #(.LO_W(LO_W), .LO_MIN(LO_MIN), .LO_MAX(LO_MAX)) u_clamp_wr (
    .raw_val(wr_data[WORD_W-1 -: LO_W]), .clamped(lo_wr));

  st_lo_clamp #(.LO_W(LO_W), .LO_MIN(LO_MIN), .LO_MAX(LO_MAX)) u_clamp_init (
    .raw_val(LO_W'(INIT_LO)), .clamped(lo_init));

  always_comb begin
    hi_n = hi_q;
    lo_n = lo_q;
    if (init_req) begin
      hi_n = '0;
      lo_n = lo_init;
    end else if (wr_en) begin
      if (st_sel_e'(wr_sel) == SEL_LO) lo_n = lo_wr;
      else                             hi_n = wr_data[HI_W-1:0];
    end
  end

  st_combine #(.HI_W(HI_W), .LO_W(LO_W), .TMO_W(TMO_W), .CYC(CYC)) u_comb_next (
    .hi(hi_n), .lo(lo_n), .total(tmo_n));

  st_combine #(.HI_W(HI_W), .LO_W(LO_W), .TMO_W(TMO_W), .CYC(CYC)) u_comb_init (
    .hi('0), .lo(lo_init), .total(tmo_init));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      lo_q  <= lo_init;
      tmo_q <= tmo_init;
    end else begin
      hi_q  <= hi_n;
      lo_q  <= lo_n;
      tmo_q <= tmo_n;
    end
  end

  st_read_mux #(.WORD_W(WORD_W), .HI_W(HI_W), .LO_W(LO_W)) u_rd (
    .sel(rd_sel), .hi(hi_q), .lo(lo_q), .word(rd_data));

  assign timeout_cycles = tmo_q;

  // Assertions
  assert_lo_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_q >= LO_W'(LO_MIN)) && (lo_q <= LO_W'(LO_MAX)));

  assert_hi_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !init_req && !wr_sel) |=> (hi_q == $past(wr_data[HI_W-1:0])));

  assert_total_R4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_cycles == TMO_W'(hi_q) * TMO_W'(CYC) + TMO_W'(lo_q));

  assert_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_req |=> (hi_q == '0) && (lo_q == lo_init));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !init_req) |=> ($stable(hi_q) && $stable(lo_q)));

  assert_hi_keeps_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !init_req && !wr_sel) |=> $stable(lo_q));
endmodule

// File: tb/test_split_timeout_regs.sv
module test_split_timeout_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_req = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic [15:0] timeout_cycles;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int hi_m;
  int lo_m;

  split_timeout_regs i_split_timeout_regs (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .timeout_cycles(timeout_cycles));

  always #10 clk = ~clk;

  function automatic int clamp_lo(input int v);
    if (v < 800) return 800;
    if (v > 7999) return 7999;
    return v;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    rd_sel = 1'b0; #1;
    chk(tag, "hi read", rd_data, longint'(hi_m));
    rd_sel = 1'b1; #1;
    chk(tag, "lo read", rd_data, longint'(lo_m) << 19);
    chk(tag, "timeout", timeout_cycles, longint'(hi_m * 8000 + lo_m));
  endtask

  task automatic wr(input bit sel, input logic [31:0] d, input bit en = 1'b1, input bit ini = 1'b0);
    @(negedge clk);
    wr_en = en; wr_sel = sel; wr_data = d; init_req = ini;
    @(negedge clk);
    wr_en = 1'b0; init_req = 1'b0; wr_data = 32'hA5A5_A5A5;
  endtask

  task automatic t_reset;
    hi_m = 0; lo_m = 800;
    check_all("R5");
    rd_sel = 1'b1; #1;
    chk("R5", "lo raw word", rd_data, 64'h1900_0000);
  endtask

  task automatic t_lo_clamp;
    int vals[6] = '{799, 800, 7999, 8000, 0, 8191};
    foreach (vals[i]) begin
      wr(1'b1, 32'(vals[i]) << 19);
      lo_m = clamp_lo(vals[i]);
      check_all("R2");
    end
    wr(1'b1, 32'hFFFF_FFFF);
    lo_m = 7999;
    check_all("R2");
  endtask

  task automatic t_lo_align;
    wr(1'b1, (32'd1234 << 19) | 32'h0007_FFFF);
    lo_m = 1234;
    check_all("R1");
    rd_sel = 1'b1; #1;
    chk("R1", "lo low bits zero", rd_data[18:0], 0);
  endtask

  task automatic t_hi_mask;
    wr(1'b0, 32'hFFFF_FFFD);
    hi_m = 5; check_all("R3");
    wr(1'b0, 32'h0000_000F);
    hi_m = 7; check_all("R3");
    wr(1'b0, 32'hFFFF_FFF8);
    hi_m = 0; check_all("R3");
  endtask

  task automatic t_total;
    wr(1'b0, 32'd7); hi_m = 7;
    wr(1'b1, 32'd7999 << 19); lo_m = 7999;
    check_all("R4");
    chk("R4", "max total", timeout_cycles, 63999);
    wr(1'b0, 32'd3); hi_m = 3;
    check_all("R4");
    wr(1'b1, 32'd1000 << 19); lo_m = 1000;
    chk("R4", "mid total", timeout_cycles, 25000);
  endtask

  task automatic t_hold;
    wr(1'b1, 32'd5000 << 19, 1'b0); check_all("R7");
    wr(1'b0, 32'd6, 1'b0);          check_all("R7");
    wr(1'b0, 32'd2); hi_m = 2;      check_all("R7");
    wr(1'b1, 32'd4000 << 19); lo_m = 4000; check_all("R7");
  endtask

  task automatic t_read;
    rd_sel = 1'b0; #1; rd_sel = 1'b1; #1; rd_sel = 1'b0; #1;
    @(negedge clk); @(negedge clk);
    check_all("R8");
  endtask

  task automatic t_init;
    wr(1'b1, 32'd6000 << 19, 1'b1, 1'b1);
    hi_m = 0; lo_m = 800;
    check_all("R6");
    wr(1'b0, 32'd4); hi_m = 4; check_all("R6");
    wr(1'b0, 32'd1, 1'b1, 1'b1); hi_m = 0; check_all("R6");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lo_clamp();
    t_lo_align();
    t_hi_mask();
    t_total();
    t_hold();
    t_read();
    t_init();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule